// File: doc/BRIEF.md
# Zero-Crossing Gain Update Controller

This block owns the active gain code of one audio channel. The serial port hands it requested 8-bit codes. The block decides when each request becomes the active code. The active code is what the analog switch network would follow. Code 0 selects the muted condition. Any code N from 1 to 255 stands for a gain of 31.5 − 0.5·(255 − N) dB. The dB mapping itself lies outside this block.

With zero-crossing detection off, a request lands on the output at once. With detection on, the request waits. A sample strobe carries the sign of the input signal, and a zero crossing is any strobe whose sign differs from the sign seen at the previous strobe. The request becomes active after two such crossings, or after a time-out of about 16 ms, whichever comes first. The active-low mute pin drives the target code to 0 through this same path. A change on the mute pin is held back while chip select is low, which is while a serial transfer is in progress. Releasing the pin brings back the stored code under the same rule.

Top module: `zc_gain_ctrl`

## Requirements
- R1: After reset, code_o is 0x00 and mute_o is 1. The stored request is 0x00, mute is inactive, and the remembered sign is 0.
- R2: While zc_en_i is 0, a differing target appears on code_o at the clock edge after the edge where the target changed. For a request, that is one edge after the edge that captured req_valid_i.
- R3: While zc_en_i is 1, a crossing is a sample_stb_i pulse whose sign_i differs from the sign at the previous strobe. A differing target commits on the edge after the second crossing that was counted from the second edge after the target changed.
- R4: While zc_en_i is 1 and fewer than two crossings occur, the target commits TMO_CYC+2 edges after it changed. TMO_CYC is (CLK_HZ/1e6)·TIMEOUT_US.
- R5: A new target that replaces a pending one restarts both the crossing count and the time-out.
- R6: While mute is in effect, the target is 0x00. mute_o is 1 exactly when code_o is 0x00. This holds for a muted state and for a requested code of 0x00 alike.
- R7: While cs_ni is 0, changes on mute_ni are ignored. The level present when cs_ni is 1 takes effect.
- R8: When mute_ni returns high, the stored request becomes the target again. It reaches code_o under the R2/R3/R4 rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Capture req_code_i as the new requested code |
| req_code_i | input | 8 | Requested gain code from the serial port |
| zc_en_i | input | 1 | 1 = wait for zero crossings or time-out |
| mute_ni | input | 1 | Mute request, active low |
| cs_ni | input | 1 | Serial chip select, low during a transfer |
| sample_stb_i | input | 1 | New audio sample available |
| sign_i | input | 1 | Sign of the current sample |
| code_o | output | 8 | Active gain code |
| mute_o | output | 1 | Channel is muted (active code is 0) |

## Verification
The bench sets CLK_HZ = 2,000,000 and TIMEOUT_US = 20, so the time-out is 40 cycles instead of millions. This lets the directed tests hit the exact commit edge of a time-out. It also lets them restart a time-out part-way through. In the random phase, with sparse strobes, many requests reach their time-outs within a short run. The crossing threshold stays at its default of 2.

// File: rtl/zc_gain_pkg.sv
package zc_gain_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] gain_code_t;
  localparam gain_code_t MUTE_CODE = '0;
endpackage

// File: rtl/zc_xing_cnt.sv
module zc_xing_cnt #(
  parameter int NEED = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic stb_i,
  input  logic sign_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(NEED + 1);
  localparam logic [CNT_W-1:0] NEED_V = CNT_W'(NEED);

  logic             last_sign_q;
  logic [CNT_W-1:0] cnt_q;
  logic             xing;

  assign xing   = stb_i && (sign_i != last_sign_q);
  assign done_o = (cnt_q == NEED_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_sign_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      if (stb_i) last_sign_q <= sign_i;
      if (clear_i)                    cnt_q <= '0;
      else if (xing && cnt_q < NEED_V) cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= NEED_V);
  assert_cnt_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
endmodule

// File: rtl/zc_timeout.sv
module zc_timeout #(
  parameter int LIMIT = 3200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic expired_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIMIT_V = W'(LIMIT);

  logic [W-1:0] age_q;

  assign expired_o = (age_q == LIMIT_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               age_q <= '0;
    else if (clear_i)          age_q <= '0;
    else if (age_q < LIMIT_V)  age_q <= age_q + 1'b1;
  end

  assert_tmo_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q <= LIMIT_V);
  assert_tmo_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> age_q == '0);
endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl
  import zc_gain_pkg::*;
#(
  parameter int CLK_HZ     = 200000000,
  parameter int TIMEOUT_US = 16000,
  parameter int ZC_NEED    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic              zc_en_i,
  input  logic              mute_ni,
  input  logic              cs_ni,
  input  logic              sample_stb_i,
  input  logic              sign_i,
  output logic [CODE_W-1:0] code_o,
  output logic              mute_o
);
  localparam int TMO_CYC = (CLK_HZ / 1000000) * TIMEOUT_US;

  gain_code_t stored_q, tgt, tgt_q, code_q;
  logic       mute_q, restart, pending, clr, commit, two_seen, expired;

  assign tgt     = mute_q ? MUTE_CODE : stored_q;
  assign restart = (tgt != tgt_q);
  assign pending = (tgt != code_q);
  assign clr     = restart || !pending;
  assign commit  = pending && (!zc_en_i || (!restart && (two_seen || expired)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stored_q <= MUTE_CODE;
      mute_q   <= 1'b0;
      tgt_q    <= MUTE_CODE;
      code_q   <= MUTE_CODE;
    end else begin
      if (req_valid_i) stored_q <= req_code_i;
      if (cs_ni)       mute_q   <= !mute_ni;  // deferred while a transfer is open
      tgt_q <= tgt;
      if (commit)      code_q   <= tgt;
    end
  end

  zc_xing_cnt #(.NEED(ZC_NEED)) u_xing (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clr),
    .stb_i  (sample_stb_i),
    .sign_i (sign_i),
    .done_o (two_seen)
  );

  zc_timeout #(.LIMIT(TMO_CYC)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clr),
    .expired_o(expired)
  );

  assign code_o = code_q;
  assign mute_o = (code_q == MUTE_CODE);

  assert_direct_apply_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zc_en_i && pending) |=> code_q == $past(tgt));
  assert_zc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zc_en_i && (restart || (!two_seen && !expired))) |=> $stable(code_q));
  assert_mute_defer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni |=> $stable(mute_q));
  assert_commit_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_q) |-> code_q == $past(tgt));
endmodule

// File: tb/zc_gain_ctrl_bench.sv
module zc_gain_ctrl_bench;
  localparam int LIM = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_v = 1'b0;
  logic [7:0] req_c = '0;
  logic       zc_en = 1'b0;
  logic       mute_n = 1'b1;
  logic       cs_n = 1'b1;
  logic       stb = 1'b0;
  logic       sgn = 1'b0;
  logic [7:0] code;
  logic       muted;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  zc_gain_ctrl #(.CLK_HZ(2000000), .TIMEOUT_US(20)) u_zc_gain_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_code_i(req_c),
    .zc_en_i(zc_en), .mute_ni(mute_n), .cs_ni(cs_n), .sample_stb_i(stb),
    .sign_i(sgn), .code_o(code), .mute_o(muted)
  );

  // reference model built from the requirements
  logic [7:0] m_req, m_code, m_prev;
  logic       m_mute, m_sign;
  int         m_x, m_age;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req <= 0; m_code <= 0; m_prev <= 0; m_mute <= 0; m_sign <= 0;
      m_x <= 0; m_age <= 0;
    end else begin
      automatic logic [7:0] t = m_mute ? 8'h00 : m_req;
      automatic bit pend = (t != m_code);
      automatic bit chg  = (t != m_prev);
      automatic bit x    = stb && (sgn != m_sign);
      if (stb) m_sign <= sgn;
      if (pend && (!zc_en || (!chg && (m_x >= 2 || m_age >= LIM)))) m_code <= t;
      if (chg || !pend) begin
        m_x <= 0; m_age <= 0;
      end else begin
        if (x && m_x < 2) m_x <= m_x + 1;
        if (m_age < LIM) m_age <= m_age + 1;
      end
      m_prev <= t;
      if (req_v) m_req <= req_c;
      if (cs_n) m_mute <= !mute_n;
    end
  end

  task automatic check(string tag, logic [7:0] exp_code, logic exp_mute);
    vectors++;
    if (code !== exp_code || muted !== exp_mute) begin
      errors++;
      $display("FAIL %s: code=%02h mute=%0b expected code=%02h mute=%0b",
               tag, code, muted, exp_code, exp_mute);
    end
  endtask

  task automatic send(logic [7:0] c);
    @(negedge clk); req_v = 1'b1; req_c = c;
    @(negedge clk); req_v = 1'b0;
  endtask

  task automatic pulse(logic s);
    @(negedge clk); stb = 1'b1; sgn = s;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(2);
    check("R1 reset", 8'h00, 1'b1);
    rst_n = 1'b1;
    idle(2);
    check("R1 after release", 8'h00, 1'b1);

    // R2 immediate update
    send(8'h80);
    check("R2 before edge", 8'h00, 1'b1);
    idle(1);
    check("R2 applied", 8'h80, 1'b0);

    // R3 two crossings
    zc_en = 1'b1;
    send(8'h40);
    idle(3);
    check("R3 held", 8'h80, 1'b0);
    pulse(1'b1);
    idle(1);
    check("R3 one crossing", 8'h80, 1'b0);
    pulse(1'b1);
    idle(1);
    check("R3 same sign no crossing", 8'h80, 1'b0);
    pulse(1'b0);
    idle(1);
    check("R3 second crossing", 8'h40, 1'b0);

    // R4 time-out
    send(8'h20);
    idle(LIM + 1);
    check("R4 before timeout", 8'h40, 1'b0);
    idle(1);
    check("R4 timeout commit", 8'h20, 1'b0);

    // R5 restart
    send(8'h10);
    idle(30);
    send(8'h11);
    idle(LIM + 1);
    check("R5 restarted hold", 8'h20, 1'b0);
    idle(1);
    check("R5 restarted commit", 8'h11, 1'b0);

    // R7 defer, R6 mute
    zc_en = 1'b0;
    @(negedge clk); cs_n = 1'b0; mute_n = 1'b0;
    idle(5);
    check("R7 mute deferred", 8'h11, 1'b0);
    cs_n = 1'b1;
    idle(2);
    check("R6 muted", 8'h00, 1'b1);

    // R8 release under zero-crossing rule
    zc_en = 1'b1;
    @(negedge clk); mute_n = 1'b1;
    idle(3);
    check("R8 still muted", 8'h00, 1'b1);
    pulse(1'b1);
    pulse(1'b0);
    idle(1);
    check("R8 restored", 8'h11, 1'b0);

    // R6 code 0 request
    zc_en = 1'b0;
    send(8'h00);
    idle(1);
    check("R6 code zero", 8'h00, 1'b1);

    // random phase against the model
    void'($urandom(32'h5eed_2024));
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      check("R2-R8 random", m_code, (m_code == 8'h00));
      req_v = ($urandom_range(0, 29) == 0);
      req_c = ($urandom_range(0, 7) == 0) ? 8'h00 : 8'($urandom);
      if ($urandom_range(0, 199) == 0) zc_en = ~zc_en;
      if ($urandom_range(0, 149) == 0) mute_n = ~mute_n;
      if ($urandom_range(0, 49) == 0) cs_n = ~cs_n;
      stb = ($urandom_range(0, 11) == 0);
      sgn = 1'($urandom);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule